// File: doc/BRIEF.md
# Multistage Synchronous Decade/Binary Counter with Fast Carry Enable

This block chains a parameterised number of 4-bit counting stages into one wide synchronous counter. Every stage runs in either decade (BCD digit, 0 to 9) or binary (0 to 15) mode, chosen at build time. All stages share one clock, one active-low asynchronous clear and one synchronous load. Two count-enable inputs, a parallel enable and a trickle enable, must both be high for the counter to advance.

A more significant stage may step only when every stage below it sits at its maximum digit. A build-time switch picks how the stage enables are wired. In the fast arrangement, the lowest stage's terminal count, qualified by the external parallel enable, is broadcast to the parallel enable of every higher stage. The trickle chain then restarts at the second stage, whose trickle enable is tied high. In the series arrangement, each stage's terminal count feeds the trickle enable of the next stage, and the external parallel enable goes to every stage. Both arrangements produce the same count sequence. No terminal count signal is ever used as a clock or as a reset.

Top module: `multistage_counter`

## Requirements
- R1: While `rst_n` is low, `count` is zero at once, without waiting for a clock edge.
- R2: With `load` high, the next rising edge copies `load_value` into `count` unchanged, including digit values above 9 in decade mode. The load takes priority over counting.
- R3: With `load` low and both `cnt_en_p` and `cnt_en_t` high, each rising edge advances `count` by one modulo 10^N (decade) or 16^N (binary), wrapping from all-maximum to zero.
- R4: With `load` low and either enable low, `count` holds its value.
- R5: Stage k (k ≥ 1) changes on a counting edge only when every stage below it is at its maximum digit (9 or 15).
- R6: `term_cnt` is high exactly when every stage holds its maximum digit and `cnt_en_t` is high. It depends on the current inputs and state, not on a later clock edge.
- R7: In decade mode, a stage that holds an illegal digit (10 to 15) goes to 0 when it advances, and a stage holding an illegal digit never counts as being at its maximum.
- R8: Fast and series wiring give identical `count` and `term_cnt` for the same stimulus.
- R9: Stage 0 occupies `count[3:0]`, and stage k occupies `count[4k+3:4k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared rising-edge clock |
| rst_n | input | 1 | Asynchronous clear, active low |
| load | input | 1 | Synchronous load of `load_value` |
| load_value | input | 4*NUM_STAGES | Value to load, with stage 0 in the low nibble |
| cnt_en_p | input | 1 | Parallel count enable |
| cnt_en_t | input | 1 | Trickle count enable; also gates `term_cnt` |
| count | output | 4*NUM_STAGES | Concatenated stage values |
| term_cnt | output | 1 | Whole-counter terminal count |

## Verification
The bench builds four copies, each with three stages: decade and binary, each in fast and in series wiring. All four are driven from the same enables and load. This brings within reach the 999-to-000 and FFF-to-000 wraps, carries that stop midway across the three stages, and the difference between a lone parallel enable and a lone trickle enable at terminal count. Only the decade copies can take illegal digits, which exercises the recovery to 0 and the blocked carry. The two wirings are compared with each other and with an integer reference on every step.

// File: rtl/mscnt_pkg.sv
package mscnt_pkg;
  localparam int DIGIT_W = 4;

  function automatic logic [DIGIT_W-1:0] digit_top(input bit decade);
    return decade ? 4'd9 : 4'd15;
  endfunction

  function automatic logic digit_is_top(input bit decade, input logic [DIGIT_W-1:0] q);
    return q == digit_top(decade);
  endfunction

  // Anything at or above the top digit (including illegal BCD codes) wraps to 0.
  function automatic logic [DIGIT_W-1:0] digit_step(input bit decade, input logic [DIGIT_W-1:0] q);
    return (q >= digit_top(decade)) ? '0 : q + 4'd1;
  endfunction
endpackage

// File: rtl/mscnt_digit.sv
module mscnt_digit
  import mscnt_pkg::*;
#(
  parameter bit DECADE = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [DIGIT_W-1:0] load_d,
  input  logic               en_par,
  input  logic               en_trk,
  output logic [DIGIT_W-1:0] q,
  output logic               tc
);
  logic               advance;
  logic               at_top;
  logic [DIGIT_W-1:0] q_next;

  assign advance = !load && en_par && en_trk;
  assign at_top  = digit_is_top(DECADE, q);
  assign tc      = at_top && en_trk;

  always_comb begin
    if (load)         q_next = load_d;
    else if (advance) q_next = digit_step(DECADE, q);
    else              q_next = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end

  assert_digit_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> q == $past(load_d));

  assert_digit_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !(en_par && en_trk)) |=> $stable(q));

  assert_digit_illegal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && q > digit_top(DECADE)) |=> q == '0);

  assert_digit_tc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> (en_trk && q == digit_top(DECADE)));
endmodule

// File: rtl/mscnt_enable_net.sv
module mscnt_enable_net #(
  parameter int NUM_STAGES  = 3,
  parameter bit FAST_WIRING = 1'b1
) (
  input  logic [NUM_STAGES-1:0] stage_tc,
  input  logic                  ext_en_p,
  input  logic                  ext_en_t,
  output logic [NUM_STAGES-1:0] stage_cep,
  output logic [NUM_STAGES-1:0] stage_cet,
  output logic                  chain_tc
);
  assign stage_cep[0] = ext_en_p;
  assign stage_cet[0] = ext_en_t;

  generate
    if (FAST_WIRING && NUM_STAGES > 1) begin : g_fast
      logic fast_en;
      // One shared gate: stage-0 terminal count qualified by the parallel enable.
      assign fast_en = stage_tc[0] & ext_en_p;
      assign stage_cet[1] = 1'b1;
      for (genvar k = 1; k < NUM_STAGES; k++) begin : g_cep
        assign stage_cep[k] = fast_en;
      end
      for (genvar k = 2; k < NUM_STAGES; k++) begin : g_cet
        assign stage_cet[k] = stage_tc[k-1];
      end
      assign chain_tc = stage_tc[NUM_STAGES-1] & stage_tc[0];
    end else begin : g_series
      for (genvar k = 1; k < NUM_STAGES; k++) begin : g_link
        assign stage_cep[k] = ext_en_p;
        assign stage_cet[k] = stage_tc[k-1];
      end
      assign chain_tc = stage_tc[NUM_STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/multistage_counter.sv
module multistage_counter
  import mscnt_pkg::*;
#(
  parameter int NUM_STAGES  = 3,
  parameter bit DECADE      = 1'b1,
  parameter bit FAST_WIRING = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic [NUM_STAGES*DIGIT_W-1:0] load_value,
  input  logic                          cnt_en_p,
  input  logic                          cnt_en_t,
  output logic [NUM_STAGES*DIGIT_W-1:0] count,
  output logic                          term_cnt
);
  localparam int CW = NUM_STAGES * DIGIT_W;

  logic [DIGIT_W-1:0]    dq [NUM_STAGES];
  logic [NUM_STAGES-1:0] tc, cep, cet;
  logic [NUM_STAGES-1:0] at_top;
  logic [NUM_STAGES-1:0] below_top;   // every stage under k is at its top digit
  logic                  all_top;
  logic                  count_step;

  mscnt_enable_net #(.NUM_STAGES(NUM_STAGES), .FAST_WIRING(FAST_WIRING)) u_enet (
    .stage_tc (tc),
    .ext_en_p (cnt_en_p),
    .ext_en_t (cnt_en_t),
    .stage_cep(cep),
    .stage_cet(cet),
    .chain_tc (term_cnt)
  );

  generate
    for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
      mscnt_digit #(.DECADE(DECADE)) u_digit (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .load_d(load_value[k*DIGIT_W +: DIGIT_W]),
        .en_par(cep[k]),
        .en_trk(cet[k]),
        .q     (dq[k]),
        .tc    (tc[k])
      );
      assign count[k*DIGIT_W +: DIGIT_W] = dq[k];
      assign at_top[k] = digit_is_top(DECADE, dq[k]);
    end

    assign below_top[0] = 1'b1;
    for (genvar k = 1; k < NUM_STAGES; k++) begin : g_below
      assign below_top[k] = below_top[k-1] & at_top[k-1];
    end

    for (genvar k = 1; k < NUM_STAGES; k++) begin : g_carry_chk
      assert_carry_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load) && dq[k] != $past(dq[k]))
          |-> $past(below_top[k] && cnt_en_p && cnt_en_t));
    end
  endgenerate

  assign all_top    = &at_top;
  assign count_step = !load && cnt_en_p && cnt_en_t;

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |-> count == '0);

  assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (count_step && all_top) |=> count == {CW{1'b0}});

  assert_hold_whole_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !(cnt_en_p && cnt_en_t)) |=> $stable(count));

  assert_term_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (all_top && cnt_en_t) |-> term_cnt);

  assert_term_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    term_cnt |-> (all_top && cnt_en_t));
endmodule

// File: tb/multistage_counter_tb.sv
module multistage_counter_tb;
  localparam int NS = 3;
  localparam int W  = 4 * NS;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic load = 1'b0;
  logic cnt_en_p = 1'b0;
  logic cnt_en_t = 1'b0;
  logic [W-1:0] dec_ld = '0;
  logic [W-1:0] bin_ld = '0;
  logic [W-1:0] dec_f, dec_s, bin_f, bin_s;
  logic tdf, tds, tbf, tbs;

  int n_chk = 0;
  int n_fail = 0;
  int rd = 0;
  int rb = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  multistage_counter #(.NUM_STAGES(NS), .DECADE(1'b1), .FAST_WIRING(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .load(load), .load_value(dec_ld),
    .cnt_en_p(cnt_en_p), .cnt_en_t(cnt_en_t), .count(dec_f), .term_cnt(tdf));
  multistage_counter #(.NUM_STAGES(NS), .DECADE(1'b1), .FAST_WIRING(1'b0)) u_dut_ds (
    .clk(clk), .rst_n(rst_n), .load(load), .load_value(dec_ld),
    .cnt_en_p(cnt_en_p), .cnt_en_t(cnt_en_t), .count(dec_s), .term_cnt(tds));
  multistage_counter #(.NUM_STAGES(NS), .DECADE(1'b0), .FAST_WIRING(1'b1)) u_dut_bf (
    .clk(clk), .rst_n(rst_n), .load(load), .load_value(bin_ld),
    .cnt_en_p(cnt_en_p), .cnt_en_t(cnt_en_t), .count(bin_f), .term_cnt(tbf));
  multistage_counter #(.NUM_STAGES(NS), .DECADE(1'b0), .FAST_WIRING(1'b0)) u_dut_bs (
    .clk(clk), .rst_n(rst_n), .load(load), .load_value(bin_ld),
    .cnt_en_p(cnt_en_p), .cnt_en_t(cnt_en_t), .count(bin_s), .term_cnt(tbs));

  // Decimal integer to packed BCD digits, lowest digit in the low nibble (R9).
  function automatic logic [W-1:0] to_bcd(input int v);
    logic [W-1:0] r = '0;
    int x = v;
    for (int i = 0; i < NS; i++) begin
      r[4*i +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    bit et = cnt_en_t;
    chk({req, " dec fast"},   dec_f, to_bcd(rd));
    chk({req, " dec series"}, dec_s, to_bcd(rd));
    chk({req, " bin fast"},   bin_f, W'(rb));
    chk({req, " bin series"}, bin_s, W'(rb));
    chk({req, " R6 dec term"}, {11'd0, tdf}, {11'd0, (rd == 999) && et});
    chk({req, " R6 bin term"}, {11'd0, tbf}, {11'd0, (rb == 4095) && et});
    chk({req, " R8 dec term match"}, {11'd0, tds}, {11'd0, tdf});
    chk({req, " R8 bin term match"}, {11'd0, tbs}, {11'd0, tbf});
  endtask

  task automatic step(input bit ld, input int dval, input int bval,
                      input bit ep, input bit et, input string req);
    @(negedge clk);
    load = ld; dec_ld = to_bcd(dval); bin_ld = W'(bval);
    cnt_en_p = ep; cnt_en_t = et;
    if (ld) begin
      rd = dval; rb = bval;
    end else if (ep && et) begin
      rd = (rd + 1) % 1000; rb = (rb + 1) % 4096;
    end
    @(posedge clk);
    #2;
    chk_all(req);
  endtask

  task automatic t_reset();
    #1 rst_n = 1'b0;
    #10;
    rd = 0; rb = 0;
    chk_all("R1 reset state");
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_load();
    step(1, 123, 'h5A7, 1, 1, "R2 load wins over count");
    step(1, 480, 'h0F3, 0, 0, "R2 load R9 nibble order");
  endtask

  task automatic t_wrap();
    step(1, 995, 'hFFB, 0, 0, "R2 preload wrap");
    for (int i = 0; i < 8; i++) step(0, 0, 0, 1, 1, "R3 R5 R8 wrap count");
  endtask

  task automatic t_hold();
    step(0, 0, 0, 0, 1, "R4 hold par low");
    step(0, 0, 0, 1, 0, "R4 hold trk low");
    step(0, 0, 0, 0, 0, "R4 hold both low");
  endtask

  task automatic t_term();
    step(1, 999, 'hFFF, 0, 0, "R6 preload top");
    step(0, 0, 0, 0, 1, "R6 R4 top with trk only");
    step(0, 0, 0, 1, 0, "R6 R4 top with par only");
    step(0, 0, 0, 1, 1, "R3 top wraps to zero");
    step(1, 99, 'h0FF, 0, 0, "R2 preload mid carry");
    step(0, 0, 0, 1, 1, "R5 two-stage carry");
  endtask

  task automatic t_illegal();
    @(negedge clk);
    load = 1'b1; dec_ld = 12'h9B9; bin_ld = '0; cnt_en_p = 1'b1; cnt_en_t = 1'b1;
    @(posedge clk); #2;
    chk("R2 raw illegal load fast", dec_f, 12'h9B9);
    chk("R2 raw illegal load series", dec_s, 12'h9B9);
    @(negedge clk);
    load = 1'b0;
    @(posedge clk); #2;
    chk("R7 illegal digit to zero fast", dec_f, 12'h900);
    chk("R7 illegal digit to zero series", dec_s, 12'h900);
    chk("R7 bin side counts", bin_f, 12'h001);
    @(negedge clk);
    load = 1'b1; dec_ld = 12'hBF9; cnt_en_t = 1'b1; cnt_en_p = 1'b0;
    @(posedge clk); #2;
    chk("R7 illegal not top term", {11'd0, tdf}, 12'd0);
    chk("R7 illegal not top term series", {11'd0, tds}, 12'd0);
  endtask

  task automatic t_async();
    step(1, 456, 'h456, 0, 0, "R2 preload before clear");
    @(negedge clk);
    cnt_en_p = 1'b1; cnt_en_t = 1'b1; load = 1'b0;
    #1 rst_n = 1'b0;
    #1;
    rd = 0; rb = 0;
    chk_all("R1 clear without clock edge");
    @(negedge clk);
    rst_n = 1'b1; cnt_en_p = 1'b0;
  endtask

  task automatic t_mixed();
    for (int i = 0; i < 400; i++) begin
      bit ld = (i % 97) == 50;
      step(ld, 990, 4090, (i % 7) != 3, (i % 11) != 5, "R3 R4 R8 mixed run");
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_load();
    t_wrap();
    t_hold();
    t_term();
    t_illegal();
    t_async();
    t_mixed();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule